// File: doc/BRIEF.md
# Competitive-Update Self-Invalidation Counter

This block sits beside the data cache of a processor node in a machine whose caches are kept coherent by pushing updates. Each cache line has a small counter of updates that have arrived since the processor last touched that line. A local read or write of the line clears the counter. When the count reaches a fixed limit, the node stops accepting updates for that line. It drops the line from its own cache with an invalidate strobe and sends the line's home node a request to stop sending updates to it.

The block only decides. Data storage, miss handling and the home directory are outside it. The cache reports three events: a line refill, a local reference and an incoming update. Each event carries a line index and may occur in any cycle. The block answers with registered pulses one cycle later. These are an acknowledge for every update, an invalidate and drop request naming the line, and a drop-miss flag when the processor references a line that this block self-invalidated.

Top module: `cu_selfinv_ctrl`

## Requirements
- R1: After reset every line is invalid, every counter is zero and all outputs are low.
- R2: A refill (`fill_vld`) makes the line valid, clears its counter and clears its self-invalidated status, so a later reference to that line reports no drop miss.
- R3: Each update to a valid line adds one to that line's counter. While the count stays below the limit, `inv_o` and `drop_req_o` stay low.
- R4: A local reference to a valid line with no update in the same cycle clears its counter. The limit then needs a full `THRESH` further updates.
- R5: The update that brings a valid line's count to `THRESH` (default 4) raises `inv_o` and `drop_req_o` together for one cycle, in the next cycle, with `evt_line_o` equal to that line. The line becomes invalid.
- R6: A reference and an update to the same valid line in the same cycle count as a reference followed by an update, which leaves the counter at 1.
- R7: An update to an invalid line changes no counter and never causes `inv_o`.
- R8: `upd_ack_o` is high for exactly one cycle, one cycle after every update, whether the line is valid or not.
- R9: A reference to a line that was self-invalidated and not yet refilled raises `drop_miss_o` in the next cycle, with `miss_line_o` equal to that line. A reference to a line that was never filled raises nothing.
- R10: Counters are kept per line, so updates to one line never move another line toward the limit.
- R11: A refill and an update to the same line in the same cycle leave that line valid with a counter of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_vld | input | 1 | A line is refilled this cycle |
| fill_line | input | IDX_W | Index of the refilled line |
| ref_vld | input | 1 | Local processor reference this cycle |
| ref_line | input | IDX_W | Index of the referenced line |
| upd_vld | input | 1 | Incoming update this cycle |
| upd_line | input | IDX_W | Index of the updated line |
| upd_ack_o | output | 1 | Acknowledge for the update of the previous cycle |
| inv_o | output | 1 | Local invalidate strobe |
| drop_req_o | output | 1 | Request to the home node to stop updates |
| evt_line_o | output | IDX_W | Line named by inv_o / drop_req_o |
| drop_miss_o | output | 1 | Previous reference hit a self-invalidated line |
| miss_line_o | output | IDX_W | Line named by drop_miss_o |

## Verification
Two events can collide in one cycle on a single line. One pair is a reference and an update; the other is a refill and an update. The bench drives each pair together at a line that already holds three updates. The same-cycle reference must leave a count of one, so three more updates must raise the invalidate and two must not. The same-cycle refill must leave a count of zero, so only the fourth further update may raise it. Each outcome is read from the invalidate and drop-request outputs, one cycle after each update.

// File: rtl/cu_pkg.sv
package cu_pkg;

  // Count after one update: a reference in the same cycle clears first.
  // The result saturates at the limit.
  function automatic int unsigned cu_next_count(input int unsigned cur,
                                                input bit ref_seen,
                                                input int unsigned limit);
    int unsigned base;
    base = ref_seen ? 0 : cur;
    return (base + 1 >= limit) ? limit : base + 1;
  endfunction

endpackage

// File: rtl/cu_line_slot.sv
module cu_line_slot #(
  parameter int THRESH = 4,
  localparam int CNT_W = $clog2(THRESH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fill_hit,
  input  logic ref_hit,
  input  logic upd_hit,
  output logic thresh_hit,
  output logic drop_miss_hit
);
  import cu_pkg::*;

  logic             valid_q;
  logic             dropped_q;
  logic [CNT_W-1:0] cnt_q;
  int unsigned      nxt_cnt;

  always_comb begin
    nxt_cnt       = cu_next_count(32'(cnt_q), ref_hit, THRESH);
    thresh_hit    = upd_hit & valid_q & ~fill_hit & (nxt_cnt == THRESH);
    drop_miss_hit = ref_hit & ~valid_q & dropped_q & ~fill_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      dropped_q <= 1'b0;
      cnt_q     <= '0;
    end else if (fill_hit) begin
      valid_q   <= 1'b1;
      dropped_q <= 1'b0;
      cnt_q     <= '0;
    end else if (thresh_hit) begin
      valid_q   <= 1'b0;
      dropped_q <= 1'b1;
      cnt_q     <= '0;
    end else if (valid_q) begin
      if (upd_hit)      cnt_q <= nxt_cnt[CNT_W-1:0];
      else if (ref_hit) cnt_q <= '0;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(THRESH));

  // R4
  ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && !upd_hit && !fill_hit && valid_q) |=> (cnt_q == '0));

  // R7
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !fill_hit) |=> ($stable(cnt_q) && !valid_q));

  // R5
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_q) |-> $past(upd_hit));

  // R11
  fill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_hit |=> (valid_q && cnt_q == '0 && !dropped_q));

endmodule

// File: rtl/cu_evt_encode.sv
module cu_evt_encode #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] hit_vec,
  output logic             any_hit,
  output logic [IDX_W-1:0] hit_idx
);
  always_comb begin
    any_hit = |hit_vec;
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/cu_selfinv_ctrl.sv
module cu_selfinv_ctrl #(
  parameter int LINES  = 16,
  parameter int THRESH = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_line,
  input  logic             ref_vld,
  input  logic [IDX_W-1:0] ref_line,
  input  logic             upd_vld,
  input  logic [IDX_W-1:0] upd_line,
  output logic             upd_ack_o,
  output logic             inv_o,
  output logic             drop_req_o,
  output logic [IDX_W-1:0] evt_line_o,
  output logic             drop_miss_o,
  output logic [IDX_W-1:0] miss_line_o
);
  logic [LINES-1:0] thresh_vec;
  logic [LINES-1:0] dmiss_vec;
  logic             thresh_any, dmiss_any;
  logic [IDX_W-1:0] thresh_idx, dmiss_idx;

  for (genvar g = 0; g < LINES; g++) begin : g_slot
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    cu_line_slot #(.THRESH(THRESH)) i_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .fill_hit     (fill_vld && fill_line == MY_IDX),
      .ref_hit      (ref_vld  && ref_line  == MY_IDX),
      .upd_hit      (upd_vld  && upd_line  == MY_IDX),
      .thresh_hit   (thresh_vec[g]),
      .drop_miss_hit(dmiss_vec[g])
    );
  end

  cu_evt_encode #(.LINES(LINES)) i_thr_enc (
    .hit_vec(thresh_vec), .any_hit(thresh_any), .hit_idx(thresh_idx));
  cu_evt_encode #(.LINES(LINES)) i_miss_enc (
    .hit_vec(dmiss_vec), .any_hit(dmiss_any), .hit_idx(dmiss_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_ack_o   <= 1'b0;
      inv_o       <= 1'b0;
      drop_req_o  <= 1'b0;
      evt_line_o  <= '0;
      drop_miss_o <= 1'b0;
      miss_line_o <= '0;
    end else begin
      upd_ack_o   <= upd_vld;
      inv_o       <= thresh_any;
      drop_req_o  <= thresh_any;
      evt_line_o  <= thresh_any ? thresh_idx : '0;
      drop_miss_o <= dmiss_any;
      miss_line_o <= dmiss_any ? dmiss_idx : '0;
    end
  end

  // R5
  one_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(thresh_vec));

  // R9
  one_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dmiss_vec));

  // R8
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |=> upd_ack_o);

  // R5
  inv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_o |-> ($past(upd_vld) && evt_line_o == $past(upd_line)));

  // R9
  miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_miss_o |-> ($past(ref_vld) && miss_line_o == $past(ref_line)));

endmodule

// File: tb/test_cu_selfinv_ctrl.sv
module test_cu_selfinv_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int THRESH = 4;
  localparam int IDX_W = $clog2(LINES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_vld = 0, ref_vld = 0, upd_vld = 0;
  logic [IDX_W-1:0] fill_line = '0, ref_line = '0, upd_line = '0;
  logic upd_ack_o, inv_o, drop_req_o, drop_miss_o;
  logic [IDX_W-1:0] evt_line_o, miss_line_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cu_selfinv_ctrl #(.LINES(LINES), .THRESH(THRESH)) i_cu_selfinv_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fill_vld(fill_vld), .fill_line(fill_line),
    .ref_vld(ref_vld), .ref_line(ref_line),
    .upd_vld(upd_vld), .upd_line(upd_line),
    .upd_ack_o(upd_ack_o), .inv_o(inv_o), .drop_req_o(drop_req_o),
    .evt_line_o(evt_line_o), .drop_miss_o(drop_miss_o),
    .miss_line_o(miss_line_o));

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle of events at a falling edge; outputs are read at the next.
  task automatic step(input bit f, input int fl, input bit r, input int rl,
                      input bit u, input int ul);
    fill_vld = f; fill_line = IDX_W'(fl);
    ref_vld  = r; ref_line  = IDX_W'(rl);
    upd_vld  = u; upd_line  = IDX_W'(ul);
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input int l);
    step(1, l, 0, 0, 0, 0);
  endtask

  task automatic upd(input string tag, input int l, input bit exp_inv);
    step(0, 0, 0, 0, 1, l);
    check({tag, " ack"}, int'(upd_ack_o), 1);
    check({tag, " inv"}, int'(inv_o), int'(exp_inv));
    check({tag, " drop_req"}, int'(drop_req_o), int'(exp_inv));
    if (exp_inv) check({tag, " line"}, int'(evt_line_o), l);
  endtask

  task automatic t_reset();
    check("R1 inv", int'(inv_o), 0);
    check("R1 drop_req", int'(drop_req_o), 0);
    check("R1 ack", int'(upd_ack_o), 0);
    check("R1 drop_miss", int'(drop_miss_o), 0);
  endtask

  task automatic t_invalid_and_limit();
    for (int k = 0; k < 6; k++) upd("R7/R8 invalid line", 3, 0);
    idle();
    check("R8 ack single", int'(upd_ack_o), 0);
    fill(3);
    for (int k = 0; k < THRESH - 1; k++) upd("R3 below limit", 3, 0);
    upd("R5 limit", 3, 1);
    idle();
    check("R5 one cycle", int'(inv_o), 0);
    upd("R7 after drop", 3, 0);
  endtask

  task automatic t_ref_clear();
    fill(5);
    for (int k = 0; k < 3; k++) upd("R4 pre", 5, 0);
    step(0, 0, 1, 5, 0, 0);
    for (int k = 0; k < 3; k++) upd("R4 post", 5, 0);
    upd("R4 limit", 5, 1);
  endtask

  task automatic t_same_ref_upd();
    fill(6);
    for (int k = 0; k < 3; k++) upd("R6 pre", 6, 0);
    step(0, 0, 1, 6, 1, 6);
    check("R6 merged inv", int'(inv_o), 0);
    upd("R6 cnt2", 6, 0);
    upd("R6 cnt3", 6, 0);
    upd("R6 limit", 6, 1);
  endtask

  task automatic t_drop_miss();
    step(0, 0, 1, 3, 0, 0);
    check("R9 drop_miss", int'(drop_miss_o), 1);
    check("R9 miss line", int'(miss_line_o), 3);
    step(0, 0, 1, 9, 0, 0);
    check("R9 never filled", int'(drop_miss_o), 0);
    fill(3);
    step(0, 0, 1, 3, 0, 0);
    check("R2 refill clears drop", int'(drop_miss_o), 0);
  endtask

  task automatic t_independent();
    fill(1);
    fill(2);
    for (int k = 0; k < 3; k++) begin
      upd("R10 a", 1, 0);
      upd("R10 b", 2, 0);
    end
    upd("R10 limit a", 1, 1);
    upd("R10 limit b", 2, 1);
  endtask

  task automatic t_fill_upd();
    fill(7);
    for (int k = 0; k < 3; k++) upd("R11 pre", 7, 0);
    step(1, 7, 0, 0, 1, 7);
    check("R11 merged inv", int'(inv_o), 0);
    check("R11 ack", int'(upd_ack_o), 1);
    for (int k = 0; k < 3; k++) upd("R11 post", 7, 0);
    upd("R11 limit", 7, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_invalid_and_limit();
    t_ref_clear();
    t_same_ref_upd();
    t_drop_miss();
    t_independent();
    t_fill_upd();
    idle();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule